// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs the bus side of an 8-bit processor one machine cycle at a time. A requester asks for a cycle type (opcode fetch, memory read, memory write, I/O read or I/O write) together with a 16-bit address and, for writes, a data byte. The sequencer then steps through the T-states of that cycle, one clock per T-state, and drives the bus pins.

The bus shares one byte-wide path between the low address byte and the data. The path carries the address during T1, while the address strobe is high. It carries write data, or takes read data, in the later T-states. The high address byte has its own pins, and a status triple tells the memory and I/O cycle types apart.

At the end of each cycle a one-clock completion pulse is raised, and for reads it comes with the captured byte. A request may be presented during the last T-state of the running cycle, so cycles can follow each other with no idle gap. A companion stage works only from the pins. It holds the low address byte when the strobe is high, forms a 10-bit device address for a 1 KB part, and decodes the upper six address bits into a chip select.

Top module: `mbus_cycle_seq`

## Requirements
- R1: After reset, and while no cycle runs: `ale`=0, `rd_n`=1, `wr_n`=1, `ad_oe`=0, `done`=0, `req_ready`=1, `dev_cs`=0 and `io_m`,`s1`,`s0` all 0.
- R2: A request is accepted on a rising edge where `req_valid`=1 and `req_ready`=1. The next clock is T1. In T1 and only in T1, `ale`=1, `ad_oe`=1 and `ad_out` is the low address byte. `addr_hi` is the high address byte in every T-state of the cycle.
- R3: The request kind codes and the status `{io_m,s1,s0}` they drive from T1 to the last T-state are: 0 opcode fetch `011`, 1 memory read `010`, 2 memory write `001`, 3 I/O read `110`, 4 I/O write `101`.
- R4: An opcode fetch lasts four T-states and every other kind lasts three. `req_ready` is 1 in the last T-state and 0 in the others. An accepted request made in the last T-state starts its T1 in the very next clock. Otherwise the block returns to idle.
- R5: `rd_n` is 0 in T2 and T3 of kinds 0, 1 and 3, and 1 at all other times. T4 of an opcode fetch has `rd_n`=1 and `ad_oe`=0.
- R6: `wr_n` is 0 in T2 and T3 of kinds 2 and 4, and 1 at all other times. In those two T-states `ad_oe`=1 and `ad_out` is the write byte.
- R7: `ad_oe` is 0 in every clock outside T1 and outside T2/T3 of a write. `ad_oe` and `rd_n`=0 are never both true.
- R8: For a read kind, `rdata` takes the value present on `ad_in` during T3. `done` is 1 for exactly the one clock after T3. That clock is T4 of an opcode fetch, and otherwise the clock after the cycle.
- R9: A write cycle also pulses `done` for the one clock after T3 and leaves `rdata` unchanged.
- R10: A request with kind code 5, 6 or 7 is ignored. No cycle starts, `ale` stays 0 and `req_ready` stays 1.
- R11: `dev_addr` is the two lowest bits of `addr_hi` above the byte held from `ad_out` when `ale` was 1. `dev_cs` is 1 exactly when `io_m`=0, `rd_n` or `wr_n` is 0, and `addr_hi[7:2]` equals `CS_BASE` (default 6'b001000, the range 2000h-23FFh).
- R12: A store-accumulator instruction run as fetch, read, read, write back to back takes 13 T-states in total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | T-state clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Cycle request present |
| req_kind | input | 3 | Cycle kind code |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Byte for write kinds |
| req_ready | output | 1 | Request can be accepted this clock |
| addr_hi | output | 8 | High address byte pins |
| ad_out | output | 8 | Shared low byte, driven value |
| ad_oe | output | 1 | Shared low byte output enable |
| ad_in | input | 8 | Shared low byte, received value |
| ale | output | 1 | Address latch strobe |
| io_m | output | 1 | 1 for I/O cycles, 0 for memory |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Byte captured in T3 of a read |
| dev_cs | output | 1 | Decoded chip select of the 1 KB device |
| dev_addr | output | 10 | Device address from latch and high lines |

## Verification
The bench builds the block with its default sizes: a 16-bit address, an 8-bit shared byte, a 10-bit device address and the chip-select base at 2000h. With these sizes every kind code, including the three unused ones, can be swept against addresses on both sides of the 2000h-23FFh window. Every ordered pair of kinds is also run back to back. That exercises every join between a four-state and a three-state cycle, where the placement of the completion pulse changes. The read byte on `ad_in` is valid only during T3, so capture in any other T-state is seen.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic [2:0] {
    K_FETCH = 3'd0,
    K_MRD   = 3'd1,
    K_MWR   = 3'd2,
    K_IORD  = 3'd3,
    K_IOWR  = 3'd4
  } kind_e;

  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_T3   = 3'd3,
    TS_T4   = 3'd4
  } ts_e;

  typedef struct packed {
    logic io_m;
    logic s1;
    logic s0;
  } stat_t;

  function automatic logic kind_ok(logic [2:0] code);
    return code <= 3'd4;
  endfunction

  function automatic stat_t status_of(kind_e k);
    stat_t st;
    case (k)
      K_FETCH: st = '{io_m: 1'b0, s1: 1'b1, s0: 1'b1};
      K_MRD:   st = '{io_m: 1'b0, s1: 1'b1, s0: 1'b0};
      K_MWR:   st = '{io_m: 1'b0, s1: 1'b0, s0: 1'b1};
      K_IORD:  st = '{io_m: 1'b1, s1: 1'b1, s0: 1'b0};
      K_IOWR:  st = '{io_m: 1'b1, s1: 1'b0, s0: 1'b1};
      default: st = '0;
    endcase
    return st;
  endfunction

  function automatic logic is_read(kind_e k);
    return (k == K_FETCH) || (k == K_MRD) || (k == K_IORD);
  endfunction

  function automatic logic is_write(kind_e k);
    return (k == K_MWR) || (k == K_IOWR);
  endfunction

  function automatic logic has_t4(kind_e k);
    return k == K_FETCH;
  endfunction

endpackage

// File: rtl/mbus_tstate_fsm.sv
module mbus_tstate_fsm
  import mbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] ad_in,
  output ts_e           t_state,
  output kind_e         kind_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic          req_ready,
  output logic          accept,
  output logic          last_t,
  output logic          done,
  output logic [DW-1:0] rdata
);

  ts_e  state_q, state_d;
  logic in_t3;

  assign in_t3     = (state_q == TS_T3);
  assign last_t    = (in_t3 && !has_t4(kind_q)) || (state_q == TS_T4);
  assign req_ready = (state_q == TS_IDLE) || last_t;
  assign accept    = req_valid && req_ready && kind_ok(req_kind);
  assign t_state   = state_q;

  always_comb begin
    state_d = state_q;
    if (accept) begin
      state_d = TS_T1;
    end else begin
      case (state_q)
        TS_T1:   state_d = TS_T2;
        TS_T2:   state_d = TS_T3;
        TS_T3:   state_d = has_t4(kind_q) ? TS_T4 : TS_IDLE;
        TS_T4:   state_d = TS_IDLE;
        default: state_d = TS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= TS_IDLE;
      kind_q  <= K_FETCH;
      addr_q  <= '0;
      wdata_q <= '0;
      done    <= 1'b0;
      rdata   <= '0;
    end else begin
      state_q <= state_d;
      done    <= in_t3;
      if (accept) begin
        kind_q  <= kind_e'(req_kind);
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (in_t3 && is_read(kind_q)) begin
        rdata <= ad_in;
      end
    end
  end

endmodule

// File: rtl/mbus_pin_gen.sv
module mbus_pin_gen
  import mbus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  localparam int HI_W = AW - DW
) (
  input  ts_e           t_state,
  input  kind_e         kind_q,
  input  logic [AW-1:0] addr_q,
  input  logic [DW-1:0] wdata_q,
  output logic [HI_W-1:0] addr_hi,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic          ale,
  output logic          io_m,
  output logic          s1,
  output logic          s0,
  output logic          rd_n,
  output logic          wr_n
);

  logic  in_cycle, in_t1, strobe_win, rd_act, wr_act;
  stat_t st;

  assign in_cycle   = (t_state != TS_IDLE);
  assign in_t1      = (t_state == TS_T1);
  assign strobe_win = (t_state == TS_T2) || (t_state == TS_T3);
  assign rd_act     = strobe_win && is_read(kind_q);
  assign wr_act     = strobe_win && is_write(kind_q);
  assign st         = in_cycle ? status_of(kind_q) : '0;

  always_comb begin
    ale     = in_t1;
    io_m    = st.io_m;
    s1      = st.s1;
    s0      = st.s0;
    rd_n    = !rd_act;
    wr_n    = !wr_act;
    addr_hi = in_cycle ? addr_q[AW-1:DW] : '0;
    ad_oe   = in_t1 || wr_act;
    if (in_t1)       ad_out = addr_q[DW-1:0];
    else if (wr_act) ad_out = wdata_q;
    else             ad_out = '0;
  end

endmodule

// File: rtl/mbus_addr_demux.sv
module mbus_addr_demux #(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int DEV_AW  = 10,
  parameter int CS_BASE = 8,
  localparam int HI_W   = AW - DW,
  localparam int CS_W   = AW - DEV_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ale,
  input  logic [DW-1:0]     ad_out,
  input  logic [HI_W-1:0]   addr_hi,
  input  logic              io_m,
  input  logic              rd_n,
  input  logic              wr_n,
  output logic              dev_cs,
  output logic [DEV_AW-1:0] dev_addr
);

  logic [DW-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   lo_q <= '0;
    else if (ale) lo_q <= ad_out;
  end

  generate
    if (DEV_AW > DW) begin : g_wide
      assign dev_addr = {addr_hi[DEV_AW-DW-1:0], lo_q};
    end else begin : g_narrow
      assign dev_addr = lo_q[DEV_AW-1:0];
    end
  endgenerate

  assign dev_cs = !io_m && (!rd_n || !wr_n) &&
                  (addr_hi[HI_W-1 -: CS_W] == CS_W'(CS_BASE));

endmodule

// File: rtl/mbus_cycle_seq.sv
module mbus_cycle_seq
  import mbus_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int DEV_AW  = 10,
  parameter int CS_BASE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              req_ready,
  output logic [AW-DW-1:0]  addr_hi,
  output logic [DW-1:0]     ad_out,
  output logic              ad_oe,
  input  logic [DW-1:0]     ad_in,
  output logic              ale,
  output logic              io_m,
  output logic              s1,
  output logic              s0,
  output logic              rd_n,
  output logic              wr_n,
  output logic              done,
  output logic [DW-1:0]     rdata,
  output logic              dev_cs,
  output logic [DEV_AW-1:0] dev_addr
);

  ts_e           t_state;
  kind_e         kind_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          accept;
  logic          last_t;

  mbus_tstate_fsm #(.AW(AW), .DW(DW)) i_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .ad_in     (ad_in),
    .t_state   (t_state),
    .kind_q    (kind_q),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q),
    .req_ready (req_ready),
    .accept    (accept),
    .last_t    (last_t),
    .done      (done),
    .rdata     (rdata)
  );

  mbus_pin_gen #(.AW(AW), .DW(DW)) i_pins (
    .t_state (t_state),
    .kind_q  (kind_q),
    .addr_q  (addr_q),
    .wdata_q (wdata_q),
    .addr_hi (addr_hi),
    .ad_out  (ad_out),
    .ad_oe   (ad_oe),
    .ale     (ale),
    .io_m    (io_m),
    .s1      (s1),
    .s0      (s0),
    .rd_n    (rd_n),
    .wr_n    (wr_n)
  );

  mbus_addr_demux #(.AW(AW), .DW(DW), .DEV_AW(DEV_AW), .CS_BASE(CS_BASE)) i_demux (
    .clk      (clk),
    .rst_n    (rst_n),
    .ale      (ale),
    .ad_out   (ad_out),
    .addr_hi  (addr_hi),
    .io_m     (io_m),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .dev_cs   (dev_cs),
    .dev_addr (dev_addr)
  );

endmodule

// File: rtl/mbus_cycle_seq_chk.sv
module mbus_cycle_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [2:0] req_kind,
  input logic       req_ready,
  input logic       accept,
  input logic       last_t,
  input logic       ale,
  input logic       io_m,
  input logic       rd_n,
  input logic       wr_n,
  input logic       ad_oe,
  input logic       done,
  input logic       dev_cs
);

  // R2: the strobe never lasts longer than T1
  p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  // R2: an accepted request raises the strobe in the next clock
  p_accept_t1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ale);

  // R5: a read strobe only begins right after T1
  p_rd_after_t1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> $past(ale));

  // R6: read and write strobes exclude each other
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n || wr_n);

  // R7: the shared byte is released while a read strobe is low
  p_release_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  // R8: completion follows a clock with a strobe low
  p_done_after_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(!rd_n || !wr_n));

  // R4: the ready flag tracks the last T-state or idle
  p_ready_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    last_t |-> req_ready);

  // R10: unused kind codes start nothing
  p_bad_kind_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind > 3'd4 && !last_t) |=> !ale);

  // R11: chip select only in memory cycles
  p_cs_memory_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dev_cs |-> !io_m);

endmodule

bind mbus_cycle_seq mbus_cycle_seq_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_kind  (req_kind),
  .req_ready (req_ready),
  .accept    (accept),
  .last_t    (last_t),
  .ale       (ale),
  .io_m      (io_m),
  .rd_n      (rd_n),
  .wr_n      (wr_n),
  .ad_oe     (ad_oe),
  .done      (done),
  .dev_cs    (dev_cs)
);

// File: tb/test_mbus_cycle_seq.sv
module test_mbus_cycle_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = 3'd0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  ad_in = '0;
  logic        req_ready, ad_oe, ale, io_m, s1, s0, rd_n, wr_n, done, dev_cs;
  logic [7:0]  addr_hi, ad_out, rdata;
  logic [9:0]  dev_addr;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [2:0]  q_kind [4];
  logic [15:0] q_addr [4];
  logic [7:0]  q_wd   [4];
  logic [7:0]  last_rdata = 8'h00;

  always #4 clk = ~clk;

  mbus_cycle_seq i_mbus_cycle_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .ale(ale), .io_m(io_m), .s1(s1), .s0(s0), .rd_n(rd_n), .wr_n(wr_n),
    .done(done), .rdata(rdata), .dev_cs(dev_cs), .dev_addr(dev_addr)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(logic [15:0] a);
    return (a[7:0] ^ a[15:8]) + 8'h3C;
  endfunction
  function automatic int len_of(logic [2:0] k);
    return (k == 3'd0) ? 4 : 3;
  endfunction
  function automatic bit rd_kind(logic [2:0] k);
    return (k == 3'd0) || (k == 3'd1) || (k == 3'd3);
  endfunction
  function automatic bit wr_kind(logic [2:0] k);
    return (k == 3'd2) || (k == 3'd4);
  endfunction
  function automatic logic [2:0] stat_of(logic [2:0] k);
    logic io = (k >= 3'd3);
    logic b1 = rd_kind(k);
    logic b0 = (k == 3'd0) || wr_kind(k);
    return {io, b1, b0};
  endfunction

  task automatic check_pins(logic [2:0] k, logic [15:0] a, logic [7:0] wd, int t);
    bit rdp = rd_kind(k) && (t == 2 || t == 3);
    bit wrp = wr_kind(k) && (t == 2 || t == 3);
    logic [2:0] st = stat_of(k);
    chk("R2", "ale", ale, (t == 1));
    chk("R2", "addr_hi", addr_hi, a[15:8]);
    chk("R3", "status", {io_m, s1, s0}, st);
    chk("R5", "rd_n", rd_n, !rdp);
    chk("R6", "wr_n", wr_n, !wrp);
    chk("R7", "ad_oe", ad_oe, (t == 1) || wrp);
    if (t == 1) chk("R2", "ad_out addr", ad_out, a[7:0]);
    if (wrp)    chk("R6", "ad_out data", ad_out, wd);
    chk("R11", "dev_cs", dev_cs, (rdp || wrp) && !st[2] && (a[15:10] == 6'b001000));
    if (rdp || wrp) chk("R11", "dev_addr", dev_addr, a[9:0]);
    chk("R4", "ready", req_ready, (t == len_of(k)));
  endtask

  task automatic chk_completion(int j);
    chk("R8", "done", done, 1'b1);
    if (rd_kind(q_kind[j])) begin
      last_rdata = mem_byte(q_addr[j]);
      chk("R8", "rdata", rdata, last_rdata);
    end else begin
      chk("R9", "rdata kept", rdata, last_rdata);
    end
  endtask

  task automatic run_seq(int n, output int tcount);
    req_kind  = q_kind[0];
    req_addr  = q_addr[0];
    req_wdata = q_wd[0];
    req_valid = 1'b1;
    @(negedge clk);
    tcount = 0;
    for (int c = 0; c < n; c++) begin
      for (int t = 1; t <= len_of(q_kind[c]); t++) begin
        check_pins(q_kind[c], q_addr[c], q_wd[c], t);
        if (t == 4) chk_completion(c);
        else if (t == 1 && c > 0 && len_of(q_kind[c-1]) == 3) chk_completion(c - 1);
        else chk("R8", "done idle", done, 1'b0);
        ad_in = (t == 3) ? mem_byte(q_addr[c]) : ~mem_byte(q_addr[c]);
        if (t == len_of(q_kind[c]) && c + 1 < n) begin
          req_kind  = q_kind[c+1];
          req_addr  = q_addr[c+1];
          req_wdata = q_wd[c+1];
          req_valid = 1'b1;
        end else begin
          req_valid = 1'b0;
        end
        @(negedge clk);
        tcount++;
      end
    end
    ad_in = 8'h00;
    if (len_of(q_kind[n-1]) == 3) chk_completion(n - 1);
    else chk("R8", "done after T4", done, 1'b0);
    chk("R4", "idle ale", ale, 1'b0);
    chk("R4", "idle ready", req_ready, 1'b1);
    chk("R1", "idle rd_n", rd_n, 1'b1);
    chk("R1", "idle oe", ad_oe, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] addrs [8] = '{16'h0000, 16'hFFFF, 16'h2000, 16'h23FF,
                                16'h2400, 16'h1FFF, 16'h2065, 16'hA55A};
    int tc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "ale", ale, 1'b0);
    chk("R1", "rd_n", rd_n, 1'b1);
    chk("R1", "wr_n", wr_n, 1'b1);
    chk("R1", "ad_oe", ad_oe, 1'b0);
    chk("R1", "done", done, 1'b0);
    chk("R1", "ready", req_ready, 1'b1);
    chk("R1", "dev_cs", dev_cs, 1'b0);
    chk("R1", "status", {io_m, s1, s0}, 3'b000);

    // single cycles: every kind against every address
    for (int k = 0; k < 5; k++) begin
      for (int i = 0; i < 8; i++) begin
        q_kind[0] = 3'(k);
        q_addr[0] = addrs[i];
        q_wd[0]   = (addrs[i][7:0] ^ 8'hC3) + 8'(k);
        run_seq(1, tc);
        chk("R4", "cycle length", tc, len_of(q_kind[0]));
      end
    end

    // back-to-back pairs of all kinds
    for (int k1 = 0; k1 < 5; k1++) begin
      for (int k2 = 0; k2 < 5; k2++) begin
        q_kind[0] = 3'(k1); q_addr[0] = 16'h2100 + 16'(k1 * 16 + k2); q_wd[0] = 8'h5A;
        q_kind[1] = 3'(k2); q_addr[1] = 16'h8300 - 16'(k2 * 7 + k1);  q_wd[1] = 8'hA5 ^ 8'(k1);
        run_seq(2, tc);
        chk("R4", "pair length", tc, len_of(q_kind[0]) + len_of(q_kind[1]));
      end
    end

    // R12 store-accumulator: fetch, two operand reads, write
    q_kind[0] = 3'd0; q_addr[0] = 16'h2010; q_wd[0] = 8'h00;
    q_kind[1] = 3'd1; q_addr[1] = 16'h2011; q_wd[1] = 8'h00;
    q_kind[2] = 3'd1; q_addr[2] = 16'h2012; q_wd[2] = 8'h00;
    q_kind[3] = 3'd2; q_addr[3] = 16'h2065; q_wd[3] = 8'h77;
    run_seq(4, tc);
    chk("R12", "store T-states", tc, 13);

    // R10 unused kind codes
    for (int k = 5; k < 8; k++) begin
      req_kind  = 3'(k);
      req_addr  = 16'h2222;
      req_valid = 1'b1;
      for (int r = 0; r < 3; r++) begin
        @(negedge clk);
        chk("R10", "ale", ale, 1'b0);
        chk("R10", "ready", req_ready, 1'b1);
        chk("R10", "rd_n", rd_n, 1'b1);
        chk("R10", "wr_n", wr_n, 1'b1);
      end
      req_valid = 1'b0;
    end
    q_kind[0] = 3'd3; q_addr[0] = 16'h0042; q_wd[0] = 8'h00;
    run_seq(1, tc);
    chk("R10", "valid after ignored", tc, 3);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule